// File: doc/BRIEF.md
# Banked Data Address Selector

This block resolves the 12-bit data-memory address of a direct-addressed operand. Its inputs are the 8-bit address field of the instruction and a one-bit mode flag. When the flag is clear, the operand goes to a fixed window. Offsets in the lower half of the field reach the bottom of RAM, and offsets in the upper half reach the special-function-register block at the top of the data space.

When the flag is set, a bank register supplies the high address nibble, so any of the sixteen 256-byte banks can be reached. The block holds this bank register and its load-immediate operation. It also raises a flag whenever the resolved address falls in the special-function-register area.

The address output is combinational from the current inputs and the stored bank. A bank load lands on the next rising clock edge, so an access made in the same cycle as a load still sees the previous bank.

Top module: `bank_addr_sel`

## Requirements
- R1: A synchronous active-low reset clears the bank register to 0, so a banked access with offset 12h resolves to 012h after reset.
- R2: With `acc_sel` = 0 and an offset of 00h to 7Fh, `addr` equals the offset (000h to 07Fh), whatever the bank register holds.
- R3: With `acc_sel` = 0 and an offset of 80h to FFh, `addr` is F00h plus the offset (F80h to FFFh), whatever the bank register holds.
- R4: With `acc_sel` = 1, `addr` is the bank register's low nibble in bits 11:8 and the offset in bits 7:0.
- R5: Only bits 3:0 of `bank_lit` select the bank; bits 7:4 have no effect on any later address.
- R6: When `bank_load` is 1 at a rising edge, `bank_lit` is stored. An access in the cycle of the load uses the old bank, and accesses from the next cycle on use the new bank.
- R7: `sfr_hit` is 1 exactly when `addr` is F80h or above. This covers the upper access-window offsets and banked accesses in bank F with offset 80h or more.
- R8: While `bank_load` is 0, the bank register keeps its value whatever `bank_lit` carries.
- R9: Reset takes priority over a load presented at the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| bank_load | input | 1 | Load the bank register from `bank_lit` at the next edge |
| bank_lit | input | 8 | Immediate bank value; low nibble used |
| acc_sel | input | 1 | 0 = fixed access window, 1 = banked |
| offset | input | 8 | Direct-address field of the instruction |
| addr | output | 12 | Resolved data-memory address |
| sfr_hit | output | 1 | Resolved address lies at F80h or above |

## Verification
The case that is hardest to reach from the ports is a load and an access in the same cycle. The address must show the old bank before the edge and the new bank after it, and this can only be seen by sampling inside the load cycle and again one cycle later. The bench holds `acc_sel` high with a fixed offset, raises `bank_load` at a falling edge, and samples once before and once after the next rising edge. A separate scenario drives reset together with a load to show that the reset wins. The banked window at the bank F boundary (offsets 7Fh and 80h) is stepped through explicitly to pin down where `sfr_hit` starts.

// File: rtl/bas_pkg.sv
// Package: shared types for the banked data address selector.
// Assumes: nothing beyond IEEE 1800-2017.
package bas_pkg;
    // Addressing mode chosen by the instruction's access-select flag.
    typedef enum logic {
        MODE_ACCESS = 1'b0,
        MODE_BANKED = 1'b1
    } acc_mode_e;
endpackage

// File: rtl/bas_bank_reg.sv
// Module: bas_bank_reg
// Holds the bank selection loaded by the load-bank-literal operation.
// Assumes: only the low SEL_W bits of the literal are meaningful, so only
// those are stored; reset is synchronous and active low and wins over a load.
module bas_bank_reg #(
    parameter int BANK_W = 8,
    parameter int SEL_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BANK_W-1:0] lit,
    output logic [SEL_W-1:0]  sel
);
    logic [SEL_W-1:0] sel_q;
    logic             unused_lit_hi;

    // Fold the ignored upper literal bits so they are visibly discarded.
    assign unused_lit_hi = ^lit[BANK_W-1:SEL_W];

    // Bank register: clear on reset, capture literal on load, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (load) begin
            sel_q <= lit[SEL_W-1:0];
        end
    end

    assign sel = sel_q;
endmodule

// File: rtl/bas_addr_map.sv
// Module: bas_addr_map
// Builds the full data address from the offset and either the fixed
// access window or the bank selection.
// Assumes: the access window splits the offset at its MSB; the lower half
// maps to the bottom of memory and the upper half to the top bank.
module bas_addr_map
    import bas_pkg::*;
#(
    parameter int OFS_W = 8,
    parameter int SEL_W = 4
) (
    input  acc_mode_e         mode,
    input  logic [OFS_W-1:0]  offset,
    input  logic [SEL_W-1:0]  bank_sel,
    output logic [SEL_W+OFS_W-1:0] addr
);
    localparam int MSB = OFS_W - 1;

    logic [SEL_W-1:0] win_hi;

    // Access-window high bits: all zero for the low half, all one for the high half.
    for (genvar g = 0; g < SEL_W; g++) begin : g_win
        assign win_hi[g] = offset[MSB];
    end

    // Choose the high address bits from the mode.
    always_comb begin
        if (mode == MODE_BANKED) begin
            addr = {bank_sel, offset};
        end else begin
            addr = {win_hi, offset};
        end
    end
endmodule

// File: rtl/bas_sfr_detect.sv
// Module: bas_sfr_detect
// Flags addresses that fall in the special-function-register area.
// Assumes: the area runs from SFR_BASE to the top of the address space.
module bas_sfr_detect #(
    parameter int                ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] SFR_BASE = 12'hF80
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    // Compare against the base of the register area.
    always_comb begin
        hit = (addr >= SFR_BASE);
    end
endmodule

// File: rtl/bank_addr_sel.sv
// Module: bank_addr_sel (top)
// Resolves a direct operand address from an offset field and an
// access-select flag, holding the bank register and flagging register-area hits.
// Assumes: addr and sfr_hit are combinational; bank loads land at the next edge.
module bank_addr_sel
    import bas_pkg::*;
#(
    parameter int                ADDR_W   = 12,
    parameter int                OFS_W    = 8,
    parameter int                BANK_W   = 8,
    parameter logic [ADDR_W-1:0] SFR_BASE = 12'hF80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bank_load,
    input  logic [BANK_W-1:0] bank_lit,
    input  logic              acc_sel,
    input  logic [OFS_W-1:0]  offset,
    output logic [ADDR_W-1:0] addr,
    output logic              sfr_hit
);
    localparam int SEL_W = ADDR_W - OFS_W;

    acc_mode_e        mode;
    logic [SEL_W-1:0] bank_sel;

    // Translate the raw flag into the mode type.
    always_comb begin
        mode = acc_sel ? MODE_BANKED : MODE_ACCESS;
    end

    bas_bank_reg #(.BANK_W(BANK_W), .SEL_W(SEL_W)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (bank_load),
        .lit   (bank_lit),
        .sel   (bank_sel)
    );

    bas_addr_map #(.OFS_W(OFS_W), .SEL_W(SEL_W)) u_map (
        .mode     (mode),
        .offset   (offset),
        .bank_sel (bank_sel),
        .addr     (addr)
    );

    bas_sfr_detect #(.ADDR_W(ADDR_W), .SFR_BASE(SFR_BASE)) u_sfr (
        .addr (addr),
        .hit  (sfr_hit)
    );
endmodule

// File: rtl/bas_checker.sv
// Module: bas_checker
// Concurrent checks for bank_addr_sel, attached with bind.
// Assumes: SFR area starts where the top bank's offset MSB is set.
module bas_checker #(
    parameter int BANK_W = 8,
    parameter int OFS_W  = 8,
    parameter int SEL_W  = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   bank_load,
    input logic [BANK_W-1:0]      bank_lit,
    input logic                   acc_sel,
    input logic [OFS_W-1:0]       offset,
    input logic [SEL_W+OFS_W-1:0] addr,
    input logic                   sfr_hit,
    input logic [SEL_W-1:0]       bank_sel
);
    // R1: leaving reset, the bank is zero.
    a_r1_reset_bank: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> bank_sel == '0);

    // R2: low access window maps to bottom of memory.
    a_r2_access_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_sel && !offset[OFS_W-1]) |-> addr[SEL_W+OFS_W-1:OFS_W] == '0);

    // R3: high access window maps to top bank and is a register hit.
    a_r3_access_sfr: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_sel && offset[OFS_W-1]) |-> (addr[SEL_W+OFS_W-1:OFS_W] == '1 && sfr_hit));

    // R4: offset always forms the low address bits.
    a_r4_offset_low: assert property (@(posedge clk) disable iff (!rst_n)
        addr[OFS_W-1:0] == offset);

    // R6: a load is visible as the bank on the next cycle.
    a_r6_load_next: assert property (@(posedge clk) disable iff (!rst_n)
        bank_load |=> bank_sel == $past(bank_lit[SEL_W-1:0]));

    // R8: with no load the bank holds.
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bank_load |=> $stable(bank_sel));

    // R7: a register hit implies top bank and upper half of the offset.
    a_r7_sfr_only_top: assert property (@(posedge clk) disable iff (!rst_n)
        sfr_hit |-> (offset[OFS_W-1] && (!acc_sel || bank_sel == '1)));
endmodule

bind bank_addr_sel bas_checker #(.BANK_W(BANK_W), .OFS_W(OFS_W), .SEL_W(SEL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bank_load (bank_load),
    .bank_lit  (bank_lit),
    .acc_sel   (acc_sel),
    .offset    (offset),
    .addr      (addr),
    .sfr_hit   (sfr_hit),
    .bank_sel  (bank_sel)
);

// File: tb/test_bank_addr_sel.sv
// Directed bench for bank_addr_sel; one task per scenario.
module test_bank_addr_sel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bank_load = 1'b0;
    logic [7:0]  bank_lit = 8'h00;
    logic        acc_sel = 1'b0;
    logic [7:0]  offset = 8'h00;
    logic [11:0] addr;
    logic        sfr_hit;

    int n_checks = 0;
    int n_fails  = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bank_addr_sel i_bank_addr_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .bank_load (bank_load),
        .bank_lit  (bank_lit),
        .acc_sel   (acc_sel),
        .offset    (offset),
        .addr      (addr),
        .sfr_hit   (sfr_hit)
    );

    task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %03h expected %03h", req, act, exp);
        end
    endtask

    // Present an access away from the edge and check address and flag.
    task automatic access(input string req, input logic sel, input logic [7:0] ofs,
                          input logic [11:0] exp_addr, input logic exp_hit);
        @(negedge clk);
        acc_sel = sel;
        offset  = ofs;
        #1;
        chk(req, addr, exp_addr);
        chk(req, {11'd0, sfr_hit}, {11'd0, exp_hit});
    endtask

    task automatic load_bank(input logic [7:0] v);
        @(negedge clk);
        bank_load = 1'b1;
        bank_lit  = v;
        @(negedge clk);
        bank_load = 1'b0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        access("R1", 1'b1, 8'h12, 12'h012, 1'b0);
    endtask

    task automatic t_access_low;
        load_bank(8'h05);
        access("R2", 1'b0, 8'h00, 12'h000, 1'b0);
        access("R2", 1'b0, 8'h40, 12'h040, 1'b0);
        access("R2", 1'b0, 8'h7F, 12'h07F, 1'b0);
    endtask

    task automatic t_access_sfr;
        access("R3", 1'b0, 8'h80, 12'hF80, 1'b1);
        access("R3", 1'b0, 8'hE8, 12'hFE8, 1'b1);
        access("R3", 1'b0, 8'hFF, 12'hFFF, 1'b1);
    endtask

    task automatic t_banked;
        access("R4", 1'b1, 8'h34, 12'h534, 1'b0);
        access("R4", 1'b1, 8'hC1, 12'h5C1, 1'b0);
    endtask

    task automatic t_sfr_edge;
        load_bank(8'h0F);
        access("R7", 1'b1, 8'h7F, 12'hF7F, 1'b0);
        access("R7", 1'b1, 8'h80, 12'hF80, 1'b1);
        load_bank(8'h0E);
        access("R7", 1'b1, 8'hFF, 12'hEFF, 1'b0);
    endtask

    task automatic t_upper_ignored;
        load_bank(8'hA3);
        access("R5", 1'b1, 8'h10, 12'h310, 1'b0);
        load_bank(8'hF0);
        access("R5", 1'b1, 8'h10, 12'h010, 1'b0);
    endtask

    task automatic t_load_timing;
        load_bank(8'h02);
        @(negedge clk);
        acc_sel   = 1'b1;
        offset    = 8'h20;
        bank_load = 1'b1;
        bank_lit  = 8'h07;
        #1;
        chk("R6 old bank in load cycle", addr, 12'h220);
        @(negedge clk);
        bank_load = 1'b0;
        #1;
        chk("R6 new bank next cycle", addr, 12'h720);
    endtask

    task automatic t_hold;
        @(negedge clk);
        bank_lit = 8'h09;
        repeat (4) @(negedge clk);
        access("R8", 1'b1, 8'h20, 12'h720, 1'b0);
    endtask

    task automatic t_reset_over_load;
        load_bank(8'h06);
        @(negedge clk);
        rst_n     = 1'b0;
        bank_load = 1'b1;
        bank_lit  = 8'h0C;
        @(negedge clk);
        rst_n     = 1'b1;
        bank_load = 1'b0;
        access("R9", 1'b1, 8'h55, 12'h055, 1'b0);
    endtask

    initial begin
        t_reset();
        t_access_low();
        t_access_sfr();
        t_banked();
        t_sfr_edge();
        t_upper_ignored();
        t_load_timing();
        t_hold();
        t_reset_over_load();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule